// File: doc/BRIEF.md
# HDR Exit/Restart Detector

This block watches the clock and data lines of a two-wire serial bus while the bus runs in a high-data-rate mode. It recognises the two special line patterns that end or separate messages in that mode. SDA edges are counted only while SCL is held low. Four falling SDA edges with SCL never rising mark the end of the mode. Two complete SDA toggles, each a fall followed by a rise, closed by an SCL rise, mark a boundary between messages. Each recognised pattern is reported as a single-cycle pulse on its own output.

The block also tracks whether the bus is in the high-data-rate mode. In normal single-data-rate mode, an upstream decoder presents each broadcast command code together with a valid strobe. A code from 0x20 to 0x23 switches the bus into the mode. After an exit pattern, the block waits for a stop condition, which is SDA rising while SCL is high. It then pulses a stop output and returns to single-data-rate mode. Both bus lines pass through two-flop synchronisers, so the system clock must run at least four times faster than the bus clock.

Top module: `hdr_pattern_detector`

## Requirements
- R1: After reset, hdrActive, exitPulse, restartPulse and stopPulse are all 0.
- R2: While hdrActive is 0, a cccValid strobe with cccCode from 0x20 to 0x23 sets hdrActive. Any other code, or such a code without the strobe, leaves hdrActive at 0.
- R3: While hdrActive is 1, four falling SDA edges with SCL low for the whole time produce exactly one exitPulse, and no restartPulse.
- R4: While hdrActive is 1, the SDA sequence fall, rise, fall, rise with SCL low, followed by an SCL rise, produces exactly one restartPulse, and hdrActive stays 1.
- R5: Any SCL rise clears the SDA edge count. A rising SDA edge is counted only after an uncounted fall. Therefore an interrupted pattern, a pattern with three toggles, or a pattern that starts with a rise produces no pulse.
- R6: After an exitPulse, the first SDA rise with SCL high produces one stopPulse, and hdrActive is 0 in that same cycle. Restart or exit patterns that appear between the exit and the stop produce no pulse.
- R7: While hdrActive is 0, no exitPulse or restartPulse is produced. While hdrActive is 1 and no exit has been seen, an SDA rise with SCL high neither produces stopPulse nor clears hdrActive.
- R8: Each pulse output is high for exactly one cycle at a time, and exitPulse and restartPulse are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw bus clock line |
| sdaIn | input | 1 | Raw bus data line |
| cccValid | input | 1 | Strobe qualifying cccCode for one cycle |
| cccCode | input | 8 | Decoded broadcast command code |
| hdrActive | output | 1 | High while the bus is in high-data-rate mode |
| exitPulse | output | 1 | One-cycle pulse when the exit pattern is seen |
| restartPulse | output | 1 | One-cycle pulse when the restart pattern is seen |
| stopPulse | output | 1 | One-cycle pulse when the stop after an exit is seen |

## Verification
The hardest state to reach from the ports is the gap between an exit and the stop that follows it. The block has left pattern counting but is still in the mode, and line activity that would otherwise form a restart must be ignored. The bench reaches this state by driving a full four-fall exit, then playing a complete restart sequence, and only then raising SDA with SCL high. It checks that the restart produced no pulse and that the mode flag cleared only at the stop. The table-driven part places near-miss patterns back to back: three toggles, a leading rise, and an SCL rise partway through. This shows that each SCL rise clears the edge count.

// File: rtl/hdr_pat_pkg.sv
package hdr_pat_pkg;

  localparam int EXIT_FALLS       = 4;
  localparam int RESTART_TOGGLES  = 2;
  localparam int EDGE_CNT_W       = $clog2(EXIT_FALLS + 1);
  localparam logic [7:0] ENTER_BASE = 8'h20;

  typedef enum logic [1:0] {
    MODE_SDR       = 2'd0,
    MODE_HDR       = 2'd1,
    MODE_WAIT_STOP = 2'd2
  } mode_e;

  typedef struct packed {
    logic countEn;
    logic countClr;
  } ctlStrobe_t;

  typedef struct packed {
    logic sclRise;
    logic exitHit;
    logic restartHit;
    logic stopHit;
  } busEvt_t;

  function automatic logic isEnterCode(input logic [7:0] code);
    return code[7:2] == ENTER_BASE[7:2];
  endfunction

endpackage

// File: rtl/hdr_sync.sv
module hdr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '1;
        else        stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '1;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/hdr_datapath.sv
module hdr_datapath
  import hdr_pat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  ctlStrobe_t ctl,
  output busEvt_t    evt
);

  localparam int CNT_W = EDGE_CNT_W;
  localparam logic [CNT_W-1:0] EXIT_LAST   = CNT_W'(EXIT_FALLS - 1);
  localparam logic [CNT_W-1:0] TOGGLE_GOAL = CNT_W'(RESTART_TOGGLES);

  logic [1:0] syncOut;
  logic       scl, sda, sclPrev, sdaPrev;
  logic       sclRise, sdaFall, sdaRise, sclLowHeld;
  logic       fallLow, riseLow;
  logic [CNT_W-1:0] fallCnt, riseCnt;

  hdr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sclIn, sdaIn}),
    .dout (syncOut)
  );

  assign scl = syncOut[1];
  assign sda = syncOut[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= scl;
      sdaPrev <= sda;
    end
  end

  always_comb begin
    sclRise    = scl & ~sclPrev;
    sdaFall    = ~sda & sdaPrev;
    sdaRise    = sda & ~sdaPrev;
    sclLowHeld = ~scl & ~sclPrev;
    fallLow    = sdaFall & sclLowHeld;
    riseLow    = sdaRise & sclLowHeld & (riseCnt < fallCnt);
  end

  always_comb begin
    evt.sclRise    = sclRise;
    evt.exitHit    = fallLow & (fallCnt == EXIT_LAST);
    evt.restartHit = sclRise & (fallCnt == TOGGLE_GOAL) & (riseCnt == TOGGLE_GOAL);
    evt.stopHit    = sdaRise & scl & sclPrev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fallCnt <= '0;
      riseCnt <= '0;
    end else if (ctl.countClr || !ctl.countEn || sclRise) begin
      fallCnt <= '0;
      riseCnt <= '0;
    end else begin
      if (fallLow) fallCnt <= fallCnt + 1'b1;
      if (riseLow) riseCnt <= riseCnt + 1'b1;
    end
  end

  // R5: an SCL rise leaves no edge count behind
  a_r5_scl_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sclRise |=> (fallCnt == '0) && (riseCnt == '0));

  // R5: rises never run ahead of falls
  a_r5_rise_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    riseCnt <= fallCnt);

  // R3: the fall count never passes the exit length
  a_r3_fall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fallCnt <= EXIT_LAST);

endmodule

// File: rtl/hdr_control.sv
module hdr_control
  import hdr_pat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cccValid,
  input  logic [7:0] cccCode,
  input  busEvt_t    evt,
  output ctlStrobe_t ctl,
  output logic       hdrActive,
  output logic       exitPulse,
  output logic       restartPulse,
  output logic       stopPulse
);

  mode_e mode, modeNext;

  always_comb begin
    modeNext = mode;
    case (mode)
      MODE_SDR:       if (cccValid && isEnterCode(cccCode)) modeNext = MODE_HDR;
      MODE_HDR:       if (evt.exitHit) modeNext = MODE_WAIT_STOP;
      MODE_WAIT_STOP: if (evt.stopHit) modeNext = MODE_SDR;
      default:        modeNext = MODE_SDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode         <= MODE_SDR;
      exitPulse    <= 1'b0;
      restartPulse <= 1'b0;
      stopPulse    <= 1'b0;
    end else begin
      mode         <= modeNext;
      exitPulse    <= (mode == MODE_HDR) && evt.exitHit;
      restartPulse <= (mode == MODE_HDR) && evt.restartHit && !evt.exitHit;
      stopPulse    <= (mode == MODE_WAIT_STOP) && evt.stopHit;
    end
  end

  assign hdrActive    = (mode != MODE_SDR);
  assign ctl.countEn  = (mode == MODE_HDR);
  assign ctl.countClr = (mode == MODE_HDR) && evt.exitHit;

  a_r8_exit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    exitPulse |=> !exitPulse);

  a_r8_restart_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    restartPulse |=> !restartPulse);

  a_r8_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stopPulse |=> !stopPulse);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(exitPulse && restartPulse));

  a_r6_leave_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hdrActive) |-> stopPulse);

  a_r2_enter_on_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdrActive) |-> $past(cccValid && isEnterCode(cccCode)));

  a_r7_silent_in_sdr: assert property (@(posedge clk) disable iff (!rst_n)
    !hdrActive |-> !exitPulse && !restartPulse);

  a_r6_still_active_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
    exitPulse |-> hdrActive);

endmodule

// File: rtl/hdr_pattern_detector.sv
module hdr_pattern_detector
  import hdr_pat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       cccValid,
  input  logic [7:0] cccCode,
  output logic       hdrActive,
  output logic       exitPulse,
  output logic       restartPulse,
  output logic       stopPulse
);

  ctlStrobe_t ctl;
  busEvt_t    evt;

  hdr_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk  (clk),
    .rst_n(rst_n),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .ctl  (ctl),
    .evt  (evt)
  );

  hdr_control u_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .cccValid    (cccValid),
    .cccCode     (cccCode),
    .evt         (evt),
    .ctl         (ctl),
    .hdrActive   (hdrActive),
    .exitPulse   (exitPulse),
    .restartPulse(restartPulse),
    .stopPulse   (stopPulse)
  );

endmodule

// File: tb/hdr_pattern_detector_tb.sv
module hdr_pattern_detector_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclIn = 1'b1;
  logic       sdaIn = 1'b1;
  logic       cccValid = 1'b0;
  logic [7:0] cccCode = 8'h00;
  logic       hdrActive, exitPulse, restartPulse, stopPulse;

  int errors = 0;
  int checks = 0;
  int exitTotal = 0;
  int restartTotal = 0;
  int stopTotal = 0;

  always #4 clk = ~clk;

  hdr_pattern_detector u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .cccValid    (cccValid),
    .cccCode     (cccCode),
    .hdrActive   (hdrActive),
    .exitPulse   (exitPulse),
    .restartPulse(restartPulse),
    .stopPulse   (stopPulse)
  );

  always @(negedge clk) begin
    exitTotal    <= exitTotal + int'(exitPulse);
    restartTotal <= restartTotal + int'(restartPulse);
    stopTotal    <= stopTotal + int'(stopPulse);
  end

  // vector: [27:8] ten {scl,sda} steps, first step in the top bits,
  // [7:6] exits, [5:4] restarts, [3:2] stops, [1] mode after, [0] needs mode
  localparam int NVEC = 8;
  localparam logic [27:0] VEC [NVEC] = '{
    {20'b11_01_00_01_00_01_11_11_11_11, 2'd0, 2'd1, 2'd0, 1'b1, 1'b1},
    {20'b11_01_00_01_11_11_11_11_11_11, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1},
    {20'b11_01_00_01_00_01_00_01_11_11, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1},
    {20'b01_00_01_11_01_00_01_11_11_11, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1},
    {20'b11_01_00_10_00_01_00_01_11_11, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1},
    {20'b11_10_11_11_11_11_11_11_11_11, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1},
    {20'b01_00_01_00_01_00_01_00_10_11, 2'd1, 2'd0, 2'd1, 1'b0, 1'b1},
    {20'b11_01_00_01_00_01_11_11_11_11, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0}
  };

  function automatic string vecTag(input int v);
    case (v)
      0: return "R4 restart";
      1: return "R5 one toggle";
      2: return "R5 three toggles";
      3: return "R5 interrupted";
      4: return "R5 leading rise";
      5: return "R7 stop without exit";
      6: return "R3/R6 exit then stop";
      default: return "R7 pattern in sdr";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic driveBus(input logic s, input logic d);
    @(negedge clk);
    sclIn = s;
    sdaIn = d;
    repeat (8) @(negedge clk);
  endtask

  task automatic sendCode(input logic v, input logic [7:0] c);
    @(negedge clk);
    cccValid = v;
    cccCode  = c;
    @(negedge clk);
    cccValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    int e0, r0, s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hdrActive", int'(hdrActive), 0);
    chk("R1 exitPulse", int'(exitPulse), 0);
    chk("R1 restartPulse", int'(restartPulse), 0);
    chk("R1 stopPulse", int'(stopPulse), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", int'(hdrActive), 0);

    // R2 codes outside the range, or without strobe, are ignored
    sendCode(1'b1, 8'h1F);
    chk("R2 code 0x1F ignored", int'(hdrActive), 0);
    sendCode(1'b1, 8'h24);
    chk("R2 code 0x24 ignored", int'(hdrActive), 0);
    sendCode(1'b0, 8'h20);
    chk("R2 no strobe ignored", int'(hdrActive), 0);
    sendCode(1'b1, 8'h23);
    chk("R2 code 0x23 enters", int'(hdrActive), 1);

    // table of bus patterns
    for (int v = 0; v < NVEC; v++) begin
      logic [27:0] vec;
      vec = VEC[v];
      if (vec[0] && !hdrActive) sendCode(1'b1, 8'h20);
      e0 = exitTotal;
      r0 = restartTotal;
      s0 = stopTotal;
      for (int s = 0; s < 10; s++) driveBus(vec[27 - 2*s], vec[26 - 2*s]);
      repeat (6) @(negedge clk);
      chk({vecTag(v), " exits"}, exitTotal - e0, int'(vec[7:6]));
      chk({vecTag(v), " restarts"}, restartTotal - r0, int'(vec[5:4]));
      chk({vecTag(v), " stops"}, stopTotal - s0, int'(vec[3:2]));
      chk({vecTag(v), " mode after"}, int'(hdrActive), int'(vec[1]));
    end

    // R6 restart pattern between exit and stop is ignored
    sendCode(1'b1, 8'h21);
    chk("R2 code 0x21 enters", int'(hdrActive), 1);
    e0 = exitTotal;
    r0 = restartTotal;
    s0 = stopTotal;
    for (int k = 0; k < 4; k++) begin
      driveBus(1'b0, 1'b1);
      driveBus(1'b0, 1'b0);
    end
    chk("R3 exit seen", exitTotal - e0, 1);
    chk("R6 mode held until stop", int'(hdrActive), 1);
    driveBus(1'b0, 1'b1);
    driveBus(1'b0, 1'b0);
    driveBus(1'b0, 1'b1);
    driveBus(1'b0, 1'b0);
    driveBus(1'b0, 1'b1);
    driveBus(1'b1, 1'b1);
    driveBus(1'b1, 1'b1);
    chk("R6 restart ignored after exit", restartTotal - r0, 0);
    chk("R6 no stop yet", stopTotal - s0, 0);
    chk("R6 still active", int'(hdrActive), 1);
    driveBus(1'b1, 1'b0);
    driveBus(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R6 stop pulse", stopTotal - s0, 1);
    chk("R6 mode cleared", int'(hdrActive), 0);
    chk("R8 single exit overall", exitTotal - e0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule